// File: doc/BRIEF.md
# Interleaved Rate-1/2 Convolutional Encoder

This block is a memory-2, rate-1/2 convolutional encoder in which every unit delay of the shift register is stretched into a line of I stages. The result is I independent constraint-length-3 encoders running time-interleaved on one datapath. Accepted input bit k only interacts with accepted bits k-I and k-2I. A burst on the channel is therefore spread over I separate codeword sequences. The trellis of the combined code has 2^(2I) states, but each component code has only four.

The block takes one information bit per clock, qualified by a valid strobe. For each accepted bit it produces two code bits. A parameter selects the code family. The feed-forward family is the (7,5) octal pair with every D replaced by D^I. The recursive systematic family has a first bit equal to the information bit and a second bit of (1+D^2I)/(1+D^I+D^2I). The second code stream can be skewed by a fixed extra delay of A clock cycles to spread bursts further.

An optional serialiser sends both streams on one wire. It is meant for an input cadence of at most one accepted bit every two cycles.

Top module: `ilvc_enc`

## Requirements
- R1: In feed-forward mode, for accepted input number k with bit x[k], the first code bit is x[k]^x[k-I]^x[k-2I] and the second code bit is x[k]^x[k-2I]. Any term with a negative index since the last reset counts as 0.
- R2: In recursive mode the feedback bit is s[k] = x[k]^s[k-I]^s[k-2I], with s at negative indices equal to 0. The first code bit is x[k] and the second code bit is s[k]^s[k-2I].
- R3: Accepted bits whose indices differ by a value other than 0, I or 2I never affect each other's code bits. A single 1 in a zero stream changes the code bits of inputs k, k+I and k+2I only (feed-forward mode).
- R4: For an input accepted at a rising edge, the first code bit appears on code_a with code_a_vld high during the following clock cycle only.
- R5: A cycle with in_vld low changes no state, and in_bit is ignored in that cycle. The next accepted bit is coded as if the idle cycle never happened, and the idle cycle produces no output strobe.
- R6: The second code bit and its strobe code_b_vld appear exactly XDLY clock cycles after code_a would carry the first bit of the same input. With XDLY = 0 both bits appear in the same cycle.
- R7: A synchronous active-high reset clears the delay lines, the skew line and the serialiser. After reset all outputs are 0, and coding restarts from an all-zero history.
- R8: With SERIAL = 1 and at most one accepted input in any two consecutive cycles, an input accepted at edge n produces its first code bit on ser_bit during cycle n+2 and its second code bit during cycle n+3, each with ser_vld high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Information bit strobe |
| in_bit | input | 1 | Information bit |
| code_a | output | 1 | First code bit |
| code_a_vld | output | 1 | First code bit strobe |
| code_b | output | 1 | Second code bit after the XDLY skew |
| code_b_vld | output | 1 | Second code bit strobe |
| ser_bit | output | 1 | Serial channel bit (0 when SERIAL = 0) |
| ser_vld | output | 1 | Serial channel strobe (0 when SERIAL = 0) |

## Verification
Three configurations are driven with the same stimulus:
- feed-forward with I = 2 and a skew of 3;
- recursive with I = 3 and no skew;
- feed-forward with I = 2 and the serialiser.

A lone 1 in a zero stream exposes the I and 2I tap positions and shows that neighbouring interleaved lanes stay untouched. An all-ones run separates the recursive response, which never dies out, from the finite feed-forward one. A pseudo-random stream with idle gaps, where in_bit toggles during the gaps, shows that idle cycles neither shift the lines nor leak into the code. A full-rate pseudo-random run and a two-cycle cadence run check values, strobe timing and the serial ordering. A reset while data is still in flight shows that the history restarts from zero.

// File: rtl/ilvc_pkg.sv
package ilvc_pkg;

    typedef enum logic {
        GEN_FEEDFWD   = 1'b0,
        GEN_RECURSIVE = 1'b1
    } gen_mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } code_pair_t;

    typedef struct packed {
        logic       fb;
        code_pair_t code;
    } enc_step_t;

    // One coding step from the current bit and the two delay-line taps.
    function automatic enc_step_t enc_step(gen_mode_e m, logic x, logic t1, logic t2);
        enc_step_t r;
        if (m == GEN_RECURSIVE) begin
            r.fb     = x ^ t1 ^ t2;
            r.code.a = x;
            r.code.b = r.fb ^ t2;
        end else begin
            r.fb     = x;
            r.code.a = x ^ t1 ^ t2;
            r.code.b = x ^ t2;
        end
        return r;
    endfunction

endpackage

// File: rtl/ilvc_dline.sv
module ilvc_dline #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_line
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else if (en) begin
                    for (int i = DEPTH - 1; i > 0; i--) stg[i] <= stg[i-1];
                    stg[0] <= d;
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/ilvc_core.sv
module ilvc_core
    import ilvc_pkg::*;
#(
    parameter int        ILV  = 2,
    parameter gen_mode_e MODE = GEN_FEEDFWD
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic       in_bit,
    output code_pair_t pair,
    output logic       pair_vld
);
    logic      tap1, tap2;
    enc_step_t eo;

    assign eo = enc_step(MODE, in_bit, tap1, tap2);

    // Two I-stage lines in series give the D^I and D^2I taps.
    ilvc_dline #(.W(1), .DEPTH(ILV)) u_line1 (
        .clk(clk), .rst(rst), .en(in_vld), .d(eo.fb), .q(tap1)
    );
    ilvc_dline #(.W(1), .DEPTH(ILV)) u_line2 (
        .clk(clk), .rst(rst), .en(in_vld), .d(tap1), .q(tap2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pair     <= '0;
            pair_vld <= 1'b0;
        end else begin
            pair_vld <= in_vld;
            pair     <= in_vld ? eo.code : '0;
        end
    end

    // R5: idle cycles leave both taps untouched
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(tap1) && $stable(tap2)));

    generate
        if (MODE == GEN_RECURSIVE) begin : g_sys_chk
            // R2: the first code bit is the information bit itself
            assert_systematic_R2: assert property (@(posedge clk) disable iff (rst)
                in_vld |=> (pair.a == $past(in_bit)));
        end
    endgenerate
endmodule

// File: rtl/ilvc_ser.sv
module ilvc_ser (
    input  logic clk,
    input  logic rst,
    input  logic a,
    input  logic a_vld,
    input  logic b,
    input  logic b_vld,
    output logic ser_bit,
    output logic ser_vld
);
    logic pend_v, pend_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_bit <= 1'b0;
            ser_vld <= 1'b0;
            pend_v  <= 1'b0;
            pend_b  <= 1'b0;
        end else if (pend_v) begin
            ser_bit <= pend_b;
            ser_vld <= 1'b1;
            pend_v  <= 1'b0;
        end else if (a_vld) begin
            ser_bit <= a;
            ser_vld <= 1'b1;
            pend_v  <= b_vld;
            pend_b  <= b;
        end else if (b_vld) begin
            ser_bit <= b;
            ser_vld <= 1'b1;
        end else begin
            ser_bit <= 1'b0;
            ser_vld <= 1'b0;
        end
    end

    // R8: the slot after a parked second bit must be free of new code bits
    assert_ser_cadence_R8: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> !(a_vld || b_vld));

    // R8: a parked second bit is only present right after a first bit was sent
    assert_ser_pair_R8: assert property (@(posedge clk) disable iff (rst)
        pend_v |-> ser_vld);
endmodule

// File: rtl/ilvc_enc.sv
module ilvc_enc
    import ilvc_pkg::*;
#(
    parameter int        ILV    = 2,
    parameter int        XDLY   = 2,
    parameter gen_mode_e MODE   = GEN_FEEDFWD,
    parameter bit        SERIAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  logic in_bit,
    output logic code_a,
    output logic code_a_vld,
    output logic code_b,
    output logic code_b_vld,
    output logic ser_bit,
    output logic ser_vld
);
    localparam int SKEW_W = 2;

    code_pair_t        pair;
    logic              pair_vld;
    logic [SKEW_W-1:0] skew_q;

    ilvc_core #(.ILV(ILV), .MODE(MODE)) u_core (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit),
        .pair(pair), .pair_vld(pair_vld)
    );

    // Second stream skew: free-running, counted in clock cycles.
    ilvc_dline #(.W(SKEW_W), .DEPTH(XDLY)) u_skew (
        .clk(clk), .rst(rst), .en(1'b1), .d({pair.b, pair_vld}), .q(skew_q)
    );

    assign code_a     = pair.a;
    assign code_a_vld = pair_vld;
    assign code_b     = skew_q[1];
    assign code_b_vld = skew_q[0];

    generate
        if (SERIAL) begin : g_ser
            ilvc_ser u_ser (
                .clk(clk), .rst(rst),
                .a(code_a), .a_vld(code_a_vld),
                .b(code_b), .b_vld(code_b_vld),
                .ser_bit(ser_bit), .ser_vld(ser_vld)
            );
        end else begin : g_par
            assign ser_bit = 1'b0;
            assign ser_vld = 1'b0;
        end
    endgenerate

    // R7: one cycle after reset no strobe is active
    assert_reset_quiet_R7: assert property (@(posedge clk)
        rst |=> (!code_a_vld && !code_b_vld && !ser_vld));

    // R4: a first-bit strobe needs an accepted input one edge earlier
    assert_a_follows_in_R4: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !code_a_vld);
endmodule

// File: tb/sim_ilvc_enc.sv
module sim_ilvc_enc;
    import ilvc_pkg::*;

    localparam int NI = 3;
    localparam int MAXN = 512;
    localparam int IL [NI] = '{2, 3, 2};
    localparam int XA [NI] = '{3, 0, 0};
    localparam bit RC [NI] = '{1'b0, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v = 1'b0, vs = 1'b0, din = 1'b0;
    always #4 clk = ~clk;

    logic av [NI], a_ [NI], bv [NI], b_ [NI], sb [NI], sv [NI];

    ilvc_enc #(.ILV(2), .XDLY(3), .MODE(GEN_FEEDFWD), .SERIAL(1'b0)) u0 (
        .clk(clk), .rst(rst), .in_vld(v), .in_bit(din),
        .code_a(a_[0]), .code_a_vld(av[0]), .code_b(b_[0]), .code_b_vld(bv[0]),
        .ser_bit(sb[0]), .ser_vld(sv[0]));
    ilvc_enc #(.ILV(3), .XDLY(0), .MODE(GEN_RECURSIVE), .SERIAL(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_vld(v), .in_bit(din),
        .code_a(a_[1]), .code_a_vld(av[1]), .code_b(b_[1]), .code_b_vld(bv[1]),
        .ser_bit(sb[1]), .ser_vld(sv[1]));
    ilvc_enc #(.ILV(2), .XDLY(0), .MODE(GEN_FEEDFWD), .SERIAL(1'b1)) u2 (
        .clk(clk), .rst(rst), .in_vld(vs), .in_bit(din),
        .code_a(a_[2]), .code_a_vld(av[2]), .code_b(b_[2]), .code_b_vld(bv[2]),
        .ser_bit(sb[2]), .ser_vld(sv[2]));

    int checks = 0, errors = 0, cyc = 0;
    string phase = "init";
    logic xh [NI][MAXN];
    logic sh [NI][MAXN];
    int   ic [NI][MAXN];
    int   nin [NI], ka [NI], kb [NI], ks [NI];

    function automatic logic sget(int i, int k);
        return (k < 0) ? 1'b0 : sh[i][k];
    endfunction

    function automatic logic exp_c1(int i, int k);
        if (RC[i]) return xh[i][k];
        return xh[i][k] ^ sget(i, k - IL[i]) ^ sget(i, k - 2*IL[i]);
    endfunction

    function automatic logic exp_c2(int i, int k);
        if (RC[i]) return sh[i][k] ^ sget(i, k - 2*IL[i]);
        return xh[i][k] ^ sget(i, k - 2*IL[i]);
    endfunction

    task automatic record(int i, logic x);
        int k = nin[i];
        xh[i][k] = x;
        sh[i][k] = RC[i] ? (x ^ sget(i, k - IL[i]) ^ sget(i, k - 2*IL[i])) : x;
        ic[i][k] = cyc;
        nin[i]++;
    endtask

    task automatic clear_model();
        for (int i = 0; i < NI; i++) begin
            nin[i] = 0; ka[i] = 0; kb[i] = 0; ks[i] = 0;
        end
    endtask

    task automatic chk(string req, logic got, logic exp, string what, int i, int k);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] inst%0d %s idx %0d got %b exp %b",
                     req, phase, i, what, k, got, exp);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < NI; i++) begin
            string vq = RC[i] ? "R2" : "R1";
            logic due;
            // stream A: R4 timing, R1/R2 value
            due = (ka[i] < nin[i]) && (ic[i][ka[i]] + 1 == cyc);
            if (due || av[i]) begin
                chk("R4", av[i], due, "a_vld", i, ka[i]);
                if (due && av[i]) chk(vq, a_[i], exp_c1(i, ka[i]), "code_a", i, ka[i]);
                if (due) ka[i]++;
            end
            // stream B: R6 timing, R1/R2 value
            due = (kb[i] < nin[i]) && (ic[i][kb[i]] + 1 + XA[i] == cyc);
            if (due || bv[i]) begin
                chk("R6", bv[i], due, "b_vld", i, kb[i]);
                if (due && bv[i]) chk(vq, b_[i], exp_c2(i, kb[i]), "code_b", i, kb[i]);
                if (due) kb[i]++;
            end
        end
        // serial on inst2: R8
        begin
            logic due;
            int   k = ks[2] / 2;
            due = (ks[2] < 2*nin[2]) && (ic[2][k] + 2 + (ks[2] % 2) == cyc);
            if (due || sv[2]) begin
                chk("R8", sv[2], due, "ser_vld", 2, ks[2]);
                if (due && sv[2])
                    chk("R8", sb[2], (ks[2] % 2) ? exp_c2(2, k) : exp_c1(2, k), "ser_bit", 2, ks[2]);
                if (due) ks[2]++;
            end
        end
    endtask

    task automatic tick(logic nv, logic nvs, logic nb);
        @(negedge clk);
        cyc++;
        if (!rst) check_all();
        v = nv; vs = nvs; din = nb;
        if (!rst) begin
            if (nv) begin record(0, nb); record(1, nb); end
            if (nvs) record(2, nb);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        cyc++;
        rst = 1'b1; v = 1'b0; vs = 1'b0; din = 1'b0;
        repeat (3) begin @(negedge clk); cyc++; end
        for (int i = 0; i < NI; i++) begin
            chk("R7", av[i] | bv[i] | sv[i] | a_[i] | b_[i] | sb[i], 1'b0, "outputs in reset", i, 0);
        end
        rst = 1'b0;
        clear_model();
    endtask

    logic [15:0] lf = 16'hACE1;
    function automatic logic [15:0] lstep(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        clear_model();
        do_reset();

        phase = "R3-impulse";
        tick(1'b1, 1'b0, 1'b1);
        for (int n = 0; n < 12; n++) tick(1'b1, 1'b0, 1'b0);

        phase = "R7-reset-in-flight";
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b1);
        do_reset();
        for (int n = 0; n < 8; n++) tick(1'b1, 1'b0, 1'b0);

        phase = "all-ones";
        for (int n = 0; n < 24; n++) tick(1'b1, 1'b0, 1'b1);

        phase = "R5-gaps";
        for (int n = 0; n < 80; n++) begin
            lf = lstep(lf);
            tick(lf[3] & lf[7], 1'b0, lf[0]);
        end

        phase = "random-full-rate";
        for (int n = 0; n < 150; n++) begin
            lf = lstep(lf);
            tick(1'b1, 1'b0, lf[0]);
        end

        do_reset();
        phase = "R8-serial";
        for (int n = 0; n < 120; n++) begin
            lf = lstep(lf);
            tick(n % 2 == 0, n % 2 == 0, lf[0]);
        end

        phase = "drain";
        for (int n = 0; n < 12; n++) tick(1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NI; i++) begin
            chk("R4", ka[i] == nin[i], 1'b1, "all A emitted", i, ka[i]);
            chk("R6", kb[i] == nin[i], 1'b1, "all B emitted", i, kb[i]);
        end
        chk("R8", ks[2] == 2*nin[2], 1'b1, "all serial emitted", 2, ks[2]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule